// File: doc/BRIEF.md
# Oversampled Serial Receiver with Sticky Error Status

This block takes in one asynchronous serial line and recovers characters from it. A strobe from outside sets the sampling rate at 16 strobes per bit. Each frame has a start bit, 7 or 8 data bits sent least-significant first, an optional parity bit that can be even or odd, and one or two stop bits. A finished character is stored in a holding register, and a data-full flag then goes high.

Three faults are detected: overrun, framing and parity. Each fault sets a flag that stays high until software clears it. While any of the three fault flags is high, the receiver will not start a new frame. The status flags use a write-zero-to-clear port, and writing a one to a flag leaves it as it is. Characters are delivered through a held register and not through a stream, so there is no valid/ready pair and no back-pressure. Software owns the data-full flag, and a new character that arrives while that flag is high is counted as an overrun.

Top module: `uart_rx_sticky`

## Requirements
- R1: After reset the data register reads 0 and the data-full, overrun, framing and parity flags are all 0.
- R2: A frame with 8 data bits, sent least-significant bit first, is stored in the data register and sets the data-full flag.
- R3: In 7-bit mode, bit 7 of the data register reads 0. Parity covers the data bits only. With cfg_par_odd_i at 0 the data bits plus the parity bit must hold an even count of ones, and with it at 1 an odd count.
- R4: When parity does not match, the character is still written to the data register, the parity flag is set, and data-full stays 0.
- R5: When the first stop bit is sampled as 0, the character is still written, the framing flag is set, and data-full stays 0.
- R6: In two-stop-bit mode the second stop bit is ignored. If it is 0, no fault is raised and no new frame starts.
- R7: If a character completes while data-full is 1, the overrun flag is set, the data register keeps the old character, and data-full stays 1.
- R8: While the overrun, framing or parity flag is 1, incoming frames are ignored and the data register and flags stay unchanged.
- R9: A write on the status port clears each flag whose write bit is 0 and leaves alone each flag whose write bit is 1. The bit positions are: bit 0 data-full, bit 1 overrun, bit 2 framing, bit 3 parity. Flags change only on a write or on a reception event.
- R10: While receive-enable is 0, no frame is received and every flag and the data register keep their values.
- R11: A low pulse on the line that is shorter than half a bit is not taken as a start bit and stores nothing.
- R12: A frame with both a parity mismatch and a zero first stop bit sets the parity and framing flags in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Oversampling strobe, 16 strobes per bit |
| rx_i | input | 1 | Serial line, idle high |
| rx_en_i | input | 1 | Receive enable |
| cfg_seven_i | input | 1 | 1 selects 7 data bits, 0 selects 8 |
| cfg_par_en_i | input | 1 | Enables the parity bit |
| cfg_par_odd_i | input | 1 | 1 selects odd parity, 0 selects even |
| cfg_two_stop_i | input | 1 | 1 selects two stop bits |
| stat_we_i | input | 1 | Status write strobe |
| stat_wdata_i | input | 4 | Status write data, a 0 bit clears that flag |
| rdata_o | output | 8 | Data register |
| full_o | output | 1 | Data-full flag |
| ovr_o | output | 1 | Overrun flag |
| frm_o | output | 1 | Framing fault flag |
| par_o | output | 1 | Parity fault flag |

## Verification
The bench targets the cases where a faulty design goes wrong quietly:
- **Overrun.** A design that overwrote the held character, or cleared data-full, would show a changed register after the second frame.
- **Faulty frames.** Frames with a parity or framing fault must still update the data register while data-full stays low. An implementation that dropped the character, or raised data-full, would give a mismatch.
- **Blocking.** A frame sent while a fault flag is set must leave everything unchanged. So must a frame sent with receive-enable low.
- **Line oddities.** A short low glitch, and a zero second stop bit, must not start a frame. A design that took either one as a start bit would store a spurious character or raise overrun.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP1,
    ST_STOP2
  } rx_state_e;

  localparam int FLAG_W   = 4;
  localparam int FLG_FULL = 0;
  localparam int FLG_OVR  = 1;
  localparam int FLG_FRM  = 2;
  localparam int FLG_PAR  = 3;
endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_i,
  output logic line_o,
  output logic fall_o
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '1;
      prev_q  <= 1'b1;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], rx_i};
      prev_q  <= chain_q[STAGES-1];
    end
  end

  assign line_o = chain_q[STAGES-1];
  assign fall_o = prev_q & ~chain_q[STAGES-1];
endmodule

// File: rtl/uart_rx_frame.sv
module uart_rx_frame
  import uart_rx_pkg::*;
#(
  parameter int DATA_MAX = 8,
  parameter int OSR      = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick_i,
  input  logic                line_i,
  input  logic                fall_i,
  input  logic                rx_en_i,
  input  logic                allow_i,
  input  logic                seven_i,
  input  logic                par_en_i,
  input  logic                par_odd_i,
  input  logic                two_stop_i,
  output logic                done_o,
  output logic [DATA_MAX-1:0] data_o,
  output logic                perr_o,
  output logic                ferr_o,
  output logic                busy_o
);
  localparam int CNT_W = $clog2(OSR);
  localparam int IDX_W = $clog2(DATA_MAX);
  localparam logic [CNT_W-1:0] CNT_MID  = CNT_W'(OSR / 2 - 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(OSR - 1);

  rx_state_e         state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [IDX_W-1:0]  idx_q;
  logic [DATA_MAX-1:0] shift_q;
  logic              pbit_q;
  logic [IDX_W-1:0]  last_idx;
  logic              bit_end;

  assign last_idx = seven_i ? IDX_W'(DATA_MAX - 2) : IDX_W'(DATA_MAX - 1);
  assign bit_end  = tick_i && (cnt_q == CNT_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      shift_q <= '0;
      pbit_q  <= 1'b0;
    end else if (!rx_en_i) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (fall_i && allow_i) begin
            state_q <= ST_START;
            cnt_q   <= '0;
          end
        end
        ST_START: begin
          if (tick_i) begin
            if (cnt_q == CNT_MID) begin
              cnt_q <= '0;
              if (!line_i) begin
                state_q <= ST_DATA;
                idx_q   <= '0;
                shift_q <= '0;
              end else begin
                state_q <= ST_IDLE;
              end
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
        end
        ST_DATA: begin
          if (tick_i) begin
            cnt_q <= cnt_q + 1'b1;
            if (bit_end) begin
              shift_q[idx_q] <= line_i;
              idx_q <= idx_q + 1'b1;
              if (idx_q == last_idx) state_q <= par_en_i ? ST_PAR : ST_STOP1;
            end
          end
        end
        ST_PAR: begin
          if (tick_i) begin
            cnt_q <= cnt_q + 1'b1;
            if (bit_end) begin
              pbit_q  <= line_i;
              state_q <= ST_STOP1;
            end
          end
        end
        ST_STOP1: begin
          if (tick_i) begin
            cnt_q <= cnt_q + 1'b1;
            if (bit_end) state_q <= two_stop_i ? ST_STOP2 : ST_IDLE;
          end
        end
        ST_STOP2: begin
          if (tick_i) begin
            cnt_q <= cnt_q + 1'b1;
            if (bit_end) state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // The character completes at the middle of the first stop bit.
  assign done_o = rx_en_i && (state_q == ST_STOP1) && bit_end;
  assign data_o = shift_q;
  assign perr_o = par_en_i && ((^shift_q ^ pbit_q) != par_odd_i);
  assign ferr_o = ~line_i;
  assign busy_o = (state_q != ST_IDLE);
endmodule

// File: rtl/uart_rx_store.sv
module uart_rx_store
  import uart_rx_pkg::*;
#(
  parameter int DATA_MAX = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                done_i,
  input  logic [DATA_MAX-1:0] data_i,
  input  logic                perr_i,
  input  logic                ferr_i,
  input  logic                we_i,
  input  logic [FLAG_W-1:0]   wdata_i,
  output logic [DATA_MAX-1:0] rdata_o,
  output logic [FLAG_W-1:0]   flags_o
);
  logic [DATA_MAX-1:0] data_q;
  logic [FLAG_W-1:0]   flag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      flag_q <= '0;
    end else begin
      // Clears first; a reception event in the same cycle overrides them.
      if (we_i) flag_q <= flag_q & wdata_i;
      if (done_i) begin
        if (flag_q[FLG_FULL]) begin
          flag_q[FLG_OVR] <= 1'b1;
        end else begin
          data_q <= data_i;
          if (perr_i || ferr_i) begin
            if (perr_i) flag_q[FLG_PAR] <= 1'b1;
            if (ferr_i) flag_q[FLG_FRM] <= 1'b1;
          end else begin
            flag_q[FLG_FULL] <= 1'b1;
          end
        end
      end
    end
  end

  assign rdata_o = data_q;
  assign flags_o = flag_q;
endmodule

// File: rtl/uart_rx_sticky.sv
module uart_rx_sticky
  import uart_rx_pkg::*;
#(
  parameter int DATA_MAX    = 8,
  parameter int OSR         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick_i,
  input  logic                rx_i,
  input  logic                rx_en_i,
  input  logic                cfg_seven_i,
  input  logic                cfg_par_en_i,
  input  logic                cfg_par_odd_i,
  input  logic                cfg_two_stop_i,
  input  logic                stat_we_i,
  input  logic [FLAG_W-1:0]   stat_wdata_i,
  output logic [DATA_MAX-1:0] rdata_o,
  output logic                full_o,
  output logic                ovr_o,
  output logic                frm_o,
  output logic                par_o
);
  logic                line;
  logic                fall;
  logic                done;
  logic [DATA_MAX-1:0] chr_data;
  logic                perr;
  logic                ferr;
  logic                frame_busy;
  logic [FLAG_W-1:0]   flags;
  logic                err_any;

  assign err_any = flags[FLG_OVR] | flags[FLG_FRM] | flags[FLG_PAR];

  uart_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .rx_i   (rx_i),
    .line_o (line),
    .fall_o (fall)
  );

  uart_rx_frame #(.DATA_MAX(DATA_MAX), .OSR(OSR)) u_frame (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_i     (tick_i),
    .line_i     (line),
    .fall_i     (fall),
    .rx_en_i    (rx_en_i),
    .allow_i    (~err_any),
    .seven_i    (cfg_seven_i),
    .par_en_i   (cfg_par_en_i),
    .par_odd_i  (cfg_par_odd_i),
    .two_stop_i (cfg_two_stop_i),
    .done_o     (done),
    .data_o     (chr_data),
    .perr_o     (perr),
    .ferr_o     (ferr),
    .busy_o     (frame_busy)
  );

  uart_rx_store #(.DATA_MAX(DATA_MAX)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .done_i  (done),
    .data_i  (chr_data),
    .perr_i  (perr),
    .ferr_i  (ferr),
    .we_i    (stat_we_i),
    .wdata_i (stat_wdata_i),
    .rdata_o (rdata_o),
    .flags_o (flags)
  );

  assign full_o = flags[FLG_FULL];
  assign ovr_o  = flags[FLG_OVR];
  assign frm_o  = flags[FLG_FRM];
  assign par_o  = flags[FLG_PAR];
endmodule

// File: rtl/uart_rx_sticky_chk.sv
module uart_rx_sticky_chk #(
  parameter int DATA_MAX = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                rx_en_i,
  input logic                stat_we_i,
  input logic [3:0]          stat_wdata_i,
  input logic [DATA_MAX-1:0] rdata_o,
  input logic                full_o,
  input logic                ovr_o,
  input logic                frm_o,
  input logic                par_o,
  input logic                frame_busy
);
  // R9
  ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_o && !stat_we_i) |=> ovr_o);
  // R9
  frm_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_o && !stat_we_i) |=> frm_o);
  // R9
  par_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (par_o && !stat_we_i) |=> par_o);
  // R9
  full_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full_o && !(stat_we_i && !stat_wdata_i[0])) |=> full_o);
  // R9
  ovr_one_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_o && stat_we_i && stat_wdata_i[1]) |=> ovr_o);
  // R7
  ovr_holds_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr_o) |-> ($stable(rdata_o) && full_o));
  // R4
  par_no_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(par_o) |-> !$rose(full_o));
  // R5
  frm_no_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frm_o) |-> !$rose(full_o));
  // R8
  err_blocks_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((ovr_o || frm_o || par_o) && !frame_busy) |=> !frame_busy);
  // R10
  disabled_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en_i |=> !frame_busy);
endmodule

bind uart_rx_sticky uart_rx_sticky_chk #(.DATA_MAX(DATA_MAX)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .rx_en_i      (rx_en_i),
  .stat_we_i    (stat_we_i),
  .stat_wdata_i (stat_wdata_i),
  .rdata_o      (rdata_o),
  .full_o       (full_o),
  .ovr_o        (ovr_o),
  .frm_o        (frm_o),
  .par_o        (par_o),
  .frame_busy   (frame_busy)
);

// File: tb/uart_rx_sticky_tb.sv
module uart_rx_sticky_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int TICK_DIV   = 4;
  localparam int BIT_CLKS   = 16 * TICK_DIV;
  localparam int WATCHDOG   = 150000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_i = 1'b0;
  logic       rx_i = 1'b1;
  logic       rx_en_i = 1'b0;
  logic       cfg_seven_i = 1'b0;
  logic       cfg_par_en_i = 1'b0;
  logic       cfg_par_odd_i = 1'b0;
  logic       cfg_two_stop_i = 1'b0;
  logic       stat_we_i = 1'b0;
  logic [3:0] stat_wdata_i = 4'hF;
  logic [7:0] rdata_o;
  logic       full_o, ovr_o, frm_o, par_o;

  uart_rx_sticky dut_i (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .rx_i(rx_i), .rx_en_i(rx_en_i),
    .cfg_seven_i(cfg_seven_i), .cfg_par_en_i(cfg_par_en_i),
    .cfg_par_odd_i(cfg_par_odd_i), .cfg_two_stop_i(cfg_two_stop_i),
    .stat_we_i(stat_we_i), .stat_wdata_i(stat_wdata_i), .rdata_o(rdata_o),
    .full_o(full_o), .ovr_o(ovr_o), .frm_o(frm_o), .par_o(par_o)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int tick_ph = 0;
  always @(negedge clk) begin
    tick_ph = (tick_ph + 1) % TICK_DIV;
    tick_i  = (tick_ph == 0);
  end

  // Reference model state
  logic [7:0] e_data = '0;
  bit e_full = 0, e_ovr = 0, e_frm = 0, e_par = 0;
  bit cmp_en = 0;
  string cur_req = "R1";
  int n_chk = 0, n_fail = 0, cyc = 0;
  bit finished = 0;

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic chk_all(string req);
    chk(req, "rdata", int'(rdata_o), int'(e_data));
    chk(req, "full", int'(full_o), int'(e_full));
    chk(req, "ovr", int'(ovr_o), int'(e_ovr));
    chk(req, "frm", int'(frm_o), int'(e_frm));
    chk(req, "par", int'(par_o), int'(e_par));
  endtask

  // Per-clock comparison against the model outside of frame flight windows.
  always @(negedge clk) begin
    #1;
    if (cmp_en && !finished) begin
      n_chk++;
      if ({rdata_o, full_o, ovr_o, frm_o, par_o} !== {e_data, e_full, e_ovr, e_frm, e_par}) begin
        n_fail++;
        $display("FAIL %s per-clock: actual %h/%b%b%b%b expected %h/%b%b%b%b", cur_req,
                 rdata_o, full_o, ovr_o, frm_o, par_o, e_data, e_full, e_ovr, e_frm, e_par);
      end
    end
  end

  task automatic finish_run();
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == WATCHDOG && !finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected below %0d cycles", cyc, WATCHDOG);
      finish_run();
    end
  end

  task automatic drive_bit(bit v);
    rx_i = v;
    repeat (BIT_CLKS) @(negedge clk);
  endtask

  task automatic stat_write(logic [3:0] w);
    @(negedge clk);
    stat_we_i = 1'b1;
    stat_wdata_i = w;
    @(negedge clk);
    stat_we_i = 1'b0;
    stat_wdata_i = 4'hF;
    e_full &= w[0];
    e_ovr  &= w[1];
    e_frm  &= w[2];
    e_par  &= w[3];
  endtask

  task automatic model_frame(logic [7:0] dm, bit pe, bit fe);
    if (rx_en_i && !(e_ovr || e_frm || e_par)) begin
      if (e_full) e_ovr = 1;
      else begin
        e_data = dm;
        if (pe || fe) begin
          if (pe) e_par = 1;
          if (fe) e_frm = 1;
        end else e_full = 1;
      end
    end
  endtask

  task automatic send_frame(logic [7:0] d, bit bad_par, bit s1, bit s2);
    int nb;
    logic [7:0] dm;
    bit p;
    nb = cfg_seven_i ? 7 : 8;
    dm = cfg_seven_i ? {1'b0, d[6:0]} : d;
    p  = (^dm) ^ cfg_par_odd_i ^ bad_par;
    cmp_en = 0;
    drive_bit(1'b0);
    for (int i = 0; i < nb; i++) drive_bit(dm[i]);
    if (cfg_par_en_i) drive_bit(p);
    drive_bit(s1);
    model_frame(dm, cfg_par_en_i && bad_par, !s1);
    cmp_en = 1;
    if (cfg_two_stop_i) drive_bit(s2);
    rx_i = 1'b1;
    repeat (BIT_CLKS) @(negedge clk);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    rx_en_i = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    chk_all("R1");
    cmp_en = 1;

    // R2: 8 data bits, no parity, one stop bit
    cur_req = "R2";
    send_frame(8'hA5, 0, 1, 1);
    chk_all("R2");
    // R9: writing ones changes nothing, a zero clears data-full
    cur_req = "R9";
    stat_write(4'hF);
    chk("R9", "full after write ones", int'(full_o), 1);
    stat_write(4'b1110);
    chk("R9", "full after write zero", int'(full_o), 0);

    // R7: overrun keeps the old character
    cur_req = "R7";
    send_frame(8'h3C, 0, 1, 1);
    send_frame(8'h81, 0, 1, 1);
    chk("R7", "ovr", int'(ovr_o), 1);
    chk("R7", "rdata kept", int'(rdata_o), 8'h3C);
    chk("R7", "full kept", int'(full_o), 1);
    // R8: a frame sent while overrun is set is ignored
    cur_req = "R8";
    send_frame(8'h55, 0, 1, 1);
    chk("R8", "rdata unchanged", int'(rdata_o), 8'h3C);
    chk_all("R8");
    stat_write(4'b0000);
    chk_all("R9");

    // R5: framing fault stores data without data-full
    cur_req = "R5";
    send_frame(8'h66, 0, 0, 1);
    chk("R5", "frm", int'(frm_o), 1);
    chk("R5", "rdata", int'(rdata_o), 8'h66);
    chk("R5", "full", int'(full_o), 0);
    // R10: disabling keeps flags and data
    cur_req = "R10";
    @(negedge clk);
    rx_en_i = 1'b0;
    repeat (8) @(negedge clk);
    chk("R10", "frm kept", int'(frm_o), 1);
    stat_write(4'b1011);
    send_frame(8'h12, 0, 1, 1);
    chk("R10", "rdata unchanged", int'(rdata_o), 8'h66);
    chk("R10", "full unchanged", int'(full_o), 0);
    @(negedge clk);
    rx_en_i = 1'b1;
    repeat (4) @(negedge clk);

    // R11: short glitch rejected
    cur_req = "R11";
    rx_i = 1'b0;
    repeat (4 * TICK_DIV) @(negedge clk);
    rx_i = 1'b1;
    repeat (3 * BIT_CLKS) @(negedge clk);
    chk("R11", "full after glitch", int'(full_o), 0);
    chk_all("R11");
    send_frame(8'h5A, 0, 1, 1);
    chk("R11", "receives after glitch", int'(rdata_o), 8'h5A);
    stat_write(4'b1110);

    // R3: 7 data bits, even parity
    cur_req = "R3";
    cfg_seven_i = 1'b1;
    cfg_par_en_i = 1'b1;
    cfg_par_odd_i = 1'b0;
    send_frame(8'hD3, 0, 1, 1);
    chk("R3", "7-bit data", int'(rdata_o), 8'h53);
    chk("R3", "no parity fault", int'(par_o), 0);
    chk("R3", "full", int'(full_o), 1);
    stat_write(4'b1110);
    // R3: odd parity, 8 bits, correct parity accepted
    cfg_seven_i = 1'b0;
    cfg_par_odd_i = 1'b1;
    send_frame(8'h0E, 0, 1, 1);
    chk("R3", "odd parity ok", int'(par_o), 0);
    stat_write(4'b1110);

    // R4: parity mismatch
    cur_req = "R4";
    send_frame(8'h0F, 1, 1, 1);
    chk("R4", "par", int'(par_o), 1);
    chk("R4", "rdata", int'(rdata_o), 8'h0F);
    chk("R4", "full", int'(full_o), 0);
    stat_write(4'b0111);

    // R12: both parity and framing faults together
    cur_req = "R12";
    send_frame(8'hC4, 1, 0, 1);
    chk("R12", "par", int'(par_o), 1);
    chk("R12", "frm", int'(frm_o), 1);
    chk("R12", "rdata", int'(rdata_o), 8'hC4);
    stat_write(4'b0011);

    // R6: second stop bit ignored
    cur_req = "R6";
    cfg_par_en_i = 1'b0;
    cfg_two_stop_i = 1'b1;
    send_frame(8'h99, 0, 1, 0);
    repeat (2 * BIT_CLKS) @(negedge clk);
    chk("R6", "rdata", int'(rdata_o), 8'h99);
    chk("R6", "no frm", int'(frm_o), 0);
    chk("R6", "no spurious start", int'(ovr_o), 0);
    stat_write(4'b1110);
    send_frame(8'h42, 0, 1, 1);
    chk("R6", "next frame", int'(rdata_o), 8'h42);
    chk_all("R6");

    finish_run();
  end
endmodule